// File: doc/BRIEF.md
# Register-Mapped GPIO, LED and Sample Pass-Through Peripheral

This block hangs off a simple processor system bus and gives software control over two rows of expansion-connector pins, called the P row and the N row, and over a bank of eight LEDs. Each row has three registers. A direction register decides, pin by pin, whether the block drives the pin. An output register holds the level to drive. A read-only input register reports the level seen on the pin after a two-flop synchroniser. A constant identification word at offset zero lets software confirm that the peripheral is present. The number of pins per row is a parameter, because board variants differ.

The same block also sits in line on two 14-bit signed ADC sample channels and two 14-bit signed DAC sample channels. Today every output copies its input unchanged. The block is the place where processing is added later without any change to the wiring around it.

Every bus access gets an acknowledge on the clock after its strobe. Read data is returned in that same cycle. Pin drivers are exposed as a value output and an enable output for each pin. The pad cell turns a cleared enable into high impedance.

Top module: `gpl_periph`

## Requirements
- R1: Each cycle in which the write strobe or the read strobe is high is followed, one clock later, by exactly one cycle with the acknowledge high. The acknowledge is low after any cycle with no strobe.
- R2: A read at offset 0x00000 returns 0xFEEDBACC. A write to that offset changes nothing that software can observe.
- R3: Offset 0x00010 holds the P-row direction and offset 0x00014 holds the N-row direction. Both read back what was written. Bit i set to 1 makes pin i an output, and 0 makes it an input.
- R4: Offset 0x00018 holds the P-row output data and offset 0x0001C holds the N-row output data. Both read back what was written. Each pin's enable equals its direction bit. A pin's value output is its data bit where enabled and 0 where not.
- R5: Offsets 0x00020 (P) and 0x00024 (N) return the pin levels through a two-stage synchroniser. Take a pin change that is set up before clock edge e1. A read whose strobe is sampled at e2 still returns the old level. A read sampled at e3 returns the new level. Writes to these offsets are ignored.
- R6: Offset 0x00030 is the LED register. Its low 8 bits drive the LED outputs from the clock edge that samples the write. Bits 31:8 read back as 0.
- R7: A read of any other offset returns 0 and is still acknowledged. A write to any other offset changes no register.
- R8: Direction, output and input register bits at or above the row-width parameter (8 by default) read back as 0.
- R9: While reset is held, acknowledge, read data, all pin enables, all pin value outputs and the LEDs are 0, and all registers clear to 0.
- R10: Each ADC output and each DAC output equals its own input at every instant, across the full signed 14-bit range.
- R11: Read data is 0 in every cycle that is not the acknowledge cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 20 | Byte offset within the peripheral |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the acknowledge cycle |
| bus_ack | output | 1 | Access acknowledge, one clock after the strobe |
| p_pin_i | input | GPIO_W | P-row pin levels from the pads |
| p_pin_o | output | GPIO_W | P-row drive values |
| p_pin_oe | output | GPIO_W | P-row drive enables (1 = drive) |
| n_pin_i | input | GPIO_W | N-row pin levels from the pads |
| n_pin_o | output | GPIO_W | N-row drive values |
| n_pin_oe | output | GPIO_W | N-row drive enables (1 = drive) |
| led | output | 8 | LED drive |
| adc_a_i | input | 14 | ADC channel A sample in (signed) |
| adc_b_i | input | 14 | ADC channel B sample in (signed) |
| adc_a_o | output | 14 | ADC channel A sample out (signed) |
| adc_b_o | output | 14 | ADC channel B sample out (signed) |
| dac_a_i | input | 14 | DAC channel A sample in (signed) |
| dac_b_i | input | 14 | DAC channel B sample in (signed) |
| dac_a_o | output | 14 | DAC channel A sample out (signed) |
| dac_b_o | output | 14 | DAC channel B sample out (signed) |

## Verification
A register that latched the wrong offset, or a lost write enable, shows up on the pin enables, the pin values or the LEDs one clock after the write. It shows up on read data one clock after the next read of that offset. A synchroniser with the wrong number of stages is caught because reads are placed exactly two and three edges after a pin change, and the first of these must return the old level. An acknowledge or read-data path that is left set, or that is missing, breaks the fixed one-cycle response. Idle cycles are also checked for zero read data.

// File: rtl/gpl_pkg.sv
package gpl_pkg;

   localparam logic [31:0] GPL_ID_WORD = 32'hFEEDBACC;

   localparam logic [31:0] OFS_ID   = 32'h0000_0000;
   localparam logic [31:0] OFS_PDIR = 32'h0000_0010;
   localparam logic [31:0] OFS_NDIR = 32'h0000_0014;
   localparam logic [31:0] OFS_POUT = 32'h0000_0018;
   localparam logic [31:0] OFS_NOUT = 32'h0000_001C;
   localparam logic [31:0] OFS_PIN  = 32'h0000_0020;
   localparam logic [31:0] OFS_NIN  = 32'h0000_0024;
   localparam logic [31:0] OFS_LED  = 32'h0000_0030;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_ID,
      SEL_PDIR,
      SEL_NDIR,
      SEL_POUT,
      SEL_NOUT,
      SEL_PIN,
      SEL_NIN,
      SEL_LED
   } reg_sel_e;

   // Exact match on the byte offset; anything else is unmapped.
   function automatic reg_sel_e gpl_decode(input logic [31:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_ID:   s = SEL_ID;
         OFS_PDIR: s = SEL_PDIR;
         OFS_NDIR: s = SEL_NDIR;
         OFS_POUT: s = SEL_POUT;
         OFS_NOUT: s = SEL_NOUT;
         OFS_PIN:  s = SEL_PIN;
         OFS_NIN:  s = SEL_NIN;
         OFS_LED:  s = SEL_LED;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpl_bus_port.sv
module gpl_bus_port
   import gpl_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic              wr_en,
   output logic              rd_en,
   output logic              ack
);
   logic [31:0] addr_ext;

   generate
      if (ADDR_W < 32) begin : g_pad
         assign addr_ext = {{(32-ADDR_W){1'b0}}, addr};
      end else begin : g_trim
         assign addr_ext = addr[31:0];
      end
   endgenerate

   assign sel   = gpl_decode(addr_ext);
   assign wr_en = wr;
   assign rd_en = rd;

   always_ff @(posedge clk) begin
      if (!rst_n) ack <= 1'b0;
      else        ack <= wr | rd;
   end
endmodule

// File: rtl/gpl_gpio_row.sv
module gpl_gpio_row #(
   parameter int W      = 8,
   parameter int SYNC_N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dir_we,
   input  logic         out_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] out_q,
   output logic [W-1:0] in_q,
   output logic [W-1:0] pin_o,
   output logic [W-1:0] pin_oe
);
   logic [W-1:0] stage [SYNC_N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
      end else begin
         if (dir_we) dir_q <= wdata;
         if (out_we) out_q <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_N; i++) stage[i] <= '0;
      end else begin
         stage[0] <= pin_i;
         for (int i = 1; i < SYNC_N; i++) stage[i] <= stage[i-1];
      end
   end

   assign in_q = stage[SYNC_N-1];

   genvar b;
   generate
      for (b = 0; b < W; b++) begin : g_pin
         assign pin_oe[b] = dir_q[b];
         assign pin_o[b]  = dir_q[b] & out_q[b];
      end
   endgenerate
endmodule

// File: rtl/gpl_sample_path.sv
module gpl_sample_path #(
   parameter int SW = 14,
   parameter int CH = 2
) (
   input  logic signed [SW-1:0] din  [CH],
   output logic signed [SW-1:0] dout [CH]
);
   genvar c;
   generate
      for (c = 0; c < CH; c++) begin : g_ch
         // Insertion point for later per-channel processing.
         assign dout[c] = din[c];
      end
   endgenerate
endmodule

// File: rtl/gpl_periph.sv
module gpl_periph
   import gpl_pkg::*;
#(
   parameter int GPIO_W = 8,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 32,
   parameter int LED_W  = 8,
   parameter int SMP_W  = 14,
   parameter int SYNC_N = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic                    bus_ack,
   input  logic [GPIO_W-1:0]       p_pin_i,
   output logic [GPIO_W-1:0]       p_pin_o,
   output logic [GPIO_W-1:0]       p_pin_oe,
   input  logic [GPIO_W-1:0]       n_pin_i,
   output logic [GPIO_W-1:0]       n_pin_o,
   output logic [GPIO_W-1:0]       n_pin_oe,
   output logic [LED_W-1:0]        led,
   input  logic signed [SMP_W-1:0] adc_a_i,
   input  logic signed [SMP_W-1:0] adc_b_i,
   output logic signed [SMP_W-1:0] adc_a_o,
   output logic signed [SMP_W-1:0] adc_b_o,
   input  logic signed [SMP_W-1:0] dac_a_i,
   input  logic signed [SMP_W-1:0] dac_b_i,
   output logic signed [SMP_W-1:0] dac_a_o,
   output logic signed [SMP_W-1:0] dac_b_o
);
   localparam int NROW  = 2;
   localparam int NCH   = 2;
   localparam int ROW_P = 0;
   localparam int ROW_N = 1;

   generate
      if (DATA_W != 32) begin : g_chk_dw
         $error("gpl_periph: DATA_W must be 32");
      end
      if (GPIO_W < 1 || GPIO_W > DATA_W) begin : g_chk_gw
         $error("gpl_periph: GPIO_W must be 1..DATA_W");
      end
      if (LED_W < 1 || LED_W > DATA_W) begin : g_chk_lw
         $error("gpl_periph: LED_W must be 1..DATA_W");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_chk_aw
         $error("gpl_periph: ADDR_W must be 8..32");
      end
      if (SYNC_N < 2) begin : g_chk_sync
         $error("gpl_periph: SYNC_N must be at least 2");
      end
   endgenerate

   reg_sel_e sel;
   logic     wr_en, rd_en;

   gpl_bus_port #(.ADDR_W(ADDR_W)) u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .rd    (bus_rd),
      .addr  (bus_addr),
      .sel   (sel),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .ack   (bus_ack)
   );

   logic [GPIO_W-1:0] row_pin_i  [NROW];
   logic [GPIO_W-1:0] row_dir    [NROW];
   logic [GPIO_W-1:0] row_out    [NROW];
   logic [GPIO_W-1:0] row_in     [NROW];
   logic [GPIO_W-1:0] row_pin_o  [NROW];
   logic [GPIO_W-1:0] row_pin_oe [NROW];

   assign row_pin_i[ROW_P] = p_pin_i;
   assign row_pin_i[ROW_N] = n_pin_i;
   assign p_pin_o  = row_pin_o[ROW_P];
   assign p_pin_oe = row_pin_oe[ROW_P];
   assign n_pin_o  = row_pin_o[ROW_N];
   assign n_pin_oe = row_pin_oe[ROW_N];

   genvar r;
   generate
      for (r = 0; r < NROW; r++) begin : g_row
         localparam reg_sel_e DIR_SEL = (r == ROW_P) ? SEL_PDIR : SEL_NDIR;
         localparam reg_sel_e OUT_SEL = (r == ROW_P) ? SEL_POUT : SEL_NOUT;
         gpl_gpio_row #(.W(GPIO_W), .SYNC_N(SYNC_N)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .dir_we (wr_en && sel == DIR_SEL),
            .out_we (wr_en && sel == OUT_SEL),
            .wdata  (bus_wdata[GPIO_W-1:0]),
            .pin_i  (row_pin_i[r]),
            .dir_q  (row_dir[r]),
            .out_q  (row_out[r]),
            .in_q   (row_in[r]),
            .pin_o  (row_pin_o[r]),
            .pin_oe (row_pin_oe[r])
         );
      end
   endgenerate

   logic [LED_W-1:0] led_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                      led_q <= '0;
      else if (wr_en && sel == SEL_LED) led_q <= bus_wdata[LED_W-1:0];
   end
   assign led = led_q;

   function automatic logic [DATA_W-1:0] zx_gpio(input logic [GPIO_W-1:0] v);
      logic [DATA_W-1:0] t;
      t = '0;
      t[GPIO_W-1:0] = v;
      return t;
   endfunction

   function automatic logic [DATA_W-1:0] zx_led(input logic [LED_W-1:0] v);
      logic [DATA_W-1:0] t;
      t = '0;
      t[LED_W-1:0] = v;
      return t;
   endfunction

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      case (sel)
         SEL_ID:   rd_mux = GPL_ID_WORD;
         SEL_PDIR: rd_mux = zx_gpio(row_dir[ROW_P]);
         SEL_NDIR: rd_mux = zx_gpio(row_dir[ROW_N]);
         SEL_POUT: rd_mux = zx_gpio(row_out[ROW_P]);
         SEL_NOUT: rd_mux = zx_gpio(row_out[ROW_N]);
         SEL_PIN:  rd_mux = zx_gpio(row_in[ROW_P]);
         SEL_NIN:  rd_mux = zx_gpio(row_in[ROW_N]);
         SEL_LED:  rd_mux = zx_led(led_q);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_mux;
      else            bus_rdata <= '0;
   end

   logic signed [SMP_W-1:0] adc_in  [NCH];
   logic signed [SMP_W-1:0] adc_out [NCH];
   logic signed [SMP_W-1:0] dac_in  [NCH];
   logic signed [SMP_W-1:0] dac_out [NCH];

   assign adc_in[0] = adc_a_i;
   assign adc_in[1] = adc_b_i;
   assign dac_in[0] = dac_a_i;
   assign dac_in[1] = dac_b_i;
   assign adc_a_o   = adc_out[0];
   assign adc_b_o   = adc_out[1];
   assign dac_a_o   = dac_out[0];
   assign dac_b_o   = dac_out[1];

   gpl_sample_path #(.SW(SMP_W), .CH(NCH)) u_adc_path (
      .din  (adc_in),
      .dout (adc_out)
   );

   gpl_sample_path #(.SW(SMP_W), .CH(NCH)) u_dac_path (
      .din  (dac_in),
      .dout (dac_out)
   );
endmodule

// File: rtl/gpl_periph_chk.sv
module gpl_periph_chk #(
   parameter int GW     = 8,
   parameter int AW     = 20,
   parameter int LW     = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [AW-1:0] bus_addr,
   input logic [31:0]   bus_wdata,
   input logic [31:0]   bus_rdata,
   input logic          bus_ack,
   input logic [GW-1:0] p_pin_o,
   input logic [GW-1:0] p_pin_oe,
   input logic [GW-1:0] n_pin_o,
   input logic [GW-1:0] n_pin_oe,
   input logic [LW-1:0] led
);
   assert_ack_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr || bus_rd) |=> bus_ack);

   assert_no_stray_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr || bus_rd) |=> !bus_ack);

   assert_id_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == '0) |=> bus_rdata == 32'hFEEDBACC);

   assert_drive_only_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((p_pin_o & ~p_pin_oe) == '0) && ((n_pin_o & ~n_pin_oe) == '0));

   assert_led_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(32'h30)) |=> led == $past(bus_wdata[LW-1:0]));

   assert_rdata_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ack |-> bus_rdata == '0);
endmodule

bind gpl_periph gpl_periph_chk #(.GW(GPIO_W), .AW(ADDR_W), .LW(LED_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bus_ack   (bus_ack),
   .p_pin_o   (p_pin_o),
   .p_pin_oe  (p_pin_oe),
   .n_pin_o   (n_pin_o),
   .n_pin_oe  (n_pin_oe),
   .led       (led)
);

// File: tb/gpl_periph_tb.sv
`timescale 1ns/1ps
module gpl_periph_tb;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [19:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic bus_ack;
   logic [W-1:0] p_pin_i = '0, n_pin_i = '0;
   logic [W-1:0] p_pin_o, p_pin_oe, n_pin_o, n_pin_oe;
   logic [7:0] led;
   logic signed [13:0] adc_a_i = '0, adc_b_i = '0, dac_a_i = '0, dac_b_i = '0;
   logic signed [13:0] adc_a_o, adc_b_o, dac_a_o, dac_b_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic rd_q = 1'b0, wr_q = 1'b0;

   always #10 clk = ~clk;

   gpl_periph u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .p_pin_i(p_pin_i), .p_pin_o(p_pin_o),
      .p_pin_oe(p_pin_oe), .n_pin_i(n_pin_i), .n_pin_o(n_pin_o),
      .n_pin_oe(n_pin_oe), .led(led), .adc_a_i(adc_a_i), .adc_b_i(adc_b_i),
      .adc_a_o(adc_a_o), .adc_b_o(adc_b_o), .dac_a_i(dac_a_i),
      .dac_b_i(dac_b_i), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Tasks are entered at a falling edge and return at the next falling edge.
   task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [19:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   always @(posedge clk) begin
      rd_q <= bus_rd;
      wr_q <= bus_wr;
   end

   // Monitor: compares the response cycle against the scoreboard queue.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (rd_q) begin
            chk("R1 read ack", 32'(bus_ack), 32'd1);
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R1: read response with empty queue, actual %h expected none", bus_rdata);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, bus_rdata, e);
            end
         end else if (wr_q) begin
            chk("R1 write ack", 32'(bus_ack), 32'd1);
            chk("R11 rdata after write", bus_rdata, 32'h0);
         end else begin
            chk("R1 idle ack", 32'(bus_ack), 32'd0);
            chk("R11 idle rdata", bus_rdata, 32'h0);
         end
      end
   end

   task automatic finish_run();
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R1: %0d reads never answered, actual %0d expected 0", exp_q.size(), exp_q.size());
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 ack", 32'(bus_ack), 32'd0);
      chk("R9 rdata", bus_rdata, 32'h0);
      chk("R9 p_oe", 32'(p_pin_oe), 32'h0);
      chk("R9 n_oe", 32'(n_pin_oe), 32'h0);
      chk("R9 p_o", 32'(p_pin_o), 32'h0);
      chk("R9 led", 32'(led), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      bus_read(20'h00000, 32'hFEEDBACC, "R2 id");
      bus_read(20'h00010, 32'h0, "R9 pdir reset");
      bus_read(20'h00014, 32'h0, "R9 ndir reset");
      bus_read(20'h00018, 32'h0, "R9 pout reset");
      bus_read(20'h0001C, 32'h0, "R9 nout reset");
      bus_read(20'h00030, 32'h0, "R9 led reset");

      // R2: write to ID is ignored
      bus_write(20'h00000, 32'h12345678);
      bus_read(20'h00000, 32'hFEEDBACC, "R2 id after write");

      // R3 / R4: P row
      bus_write(20'h00010, 32'h0000000F);
      bus_write(20'h00018, 32'h000000A5);
      chk("R4 p_oe", 32'(p_pin_oe), 32'h0F);
      chk("R4 p_o", 32'(p_pin_o), 32'h05);
      bus_read(20'h00010, 32'h0F, "R3 pdir");
      bus_read(20'h00018, 32'hA5, "R4 pout");
      // N row
      bus_write(20'h00014, 32'h000000F0);
      bus_write(20'h0001C, 32'h0000003C);
      chk("R4 n_oe", 32'(n_pin_oe), 32'hF0);
      chk("R4 n_o", 32'(n_pin_o), 32'h30);
      chk("R4 p_oe unchanged", 32'(p_pin_oe), 32'h0F);
      bus_read(20'h00014, 32'hF0, "R3 ndir");
      bus_read(20'h0001C, 32'h3C, "R4 nout");

      // R8: bits above row width
      bus_write(20'h00010, 32'hFFFFFFFF);
      chk("R8 p_oe all", 32'(p_pin_oe), 32'hFF);
      bus_read(20'h00010, 32'h000000FF, "R8 pdir upper zero");
      bus_write(20'h0001C, 32'hFFFFFF00);
      bus_read(20'h0001C, 32'h0, "R8 nout upper zero");
      bus_write(20'h00010, 32'h0000000F);
      bus_write(20'h0001C, 32'h0000003C);

      // R5: two-stage synchroniser timing, P row
      p_pin_i = 8'h5A;
      @(negedge clk);
      bus_read(20'h00020, 32'h00, "R5 pin old at e2");
      bus_read(20'h00020, 32'h5A, "R5 pin new at e3");
      bus_write(20'h00020, 32'hFFFFFFFF);
      bus_read(20'h00020, 32'h5A, "R5 pin write ignored");
      // N row
      n_pin_i = 8'hC3;
      repeat (3) @(negedge clk);
      bus_read(20'h00024, 32'hC3, "R5 nin");
      p_pin_i = 8'hFF;
      repeat (3) @(negedge clk);
      bus_read(20'h00020, 32'hFF, "R8 pin full row");

      // R6: LED
      bus_write(20'h00030, 32'hFFFFFF96);
      chk("R6 led", 32'(led), 32'h96);
      bus_read(20'h00030, 32'h96, "R6 led readback");

      // R7: unmapped offsets
      bus_read(20'h00004, 32'h0, "R7 unmapped 04");
      bus_read(20'h0002C, 32'h0, "R7 unmapped 2C");
      bus_read(20'h00040, 32'h0, "R7 unmapped 40");
      bus_read(20'hFFFFC, 32'h0, "R7 unmapped top");
      bus_write(20'h00008, 32'hFFFFFFFF);
      bus_write(20'h00110, 32'hFFFFFFFF);
      bus_write(20'h10030, 32'h00000000);
      chk("R7 led kept", 32'(led), 32'h96);
      chk("R7 p_oe kept", 32'(p_pin_oe), 32'h0F);
      bus_read(20'h00010, 32'h0F, "R7 pdir kept");
      bus_read(20'h00014, 32'hF0, "R7 ndir kept");
      bus_read(20'h00018, 32'hA5, "R7 pout kept");

      // R10: sample pass-through
      begin
         logic signed [13:0] pats [6];
         pats[0] = 14'sd0;     pats[1] = 14'sd8191;  pats[2] = -14'sd8192;
         pats[3] = -14'sd1;    pats[4] = 14'sd1234;  pats[5] = -14'sd4321;
         for (int i = 0; i < 6; i++) begin
            adc_a_i = pats[i];
            adc_b_i = pats[(i+1)%6];
            dac_a_i = pats[(i+2)%6];
            dac_b_i = pats[(i+3)%6];
            #1;
            chk("R10 adc_a", 32'(adc_a_o), 32'(pats[i]));
            chk("R10 adc_b", 32'(adc_b_o), 32'(pats[(i+1)%6]));
            chk("R10 dac_a", 32'(dac_a_o), 32'(pats[(i+2)%6]));
            chk("R10 dac_b", 32'(dac_b_o), 32'(pats[(i+3)%6]));
            @(negedge clk);
         end
      end

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule